// File: doc/BRIEF.md
# SPI Interrupt and FIFO Status Controller

This block sits next to an SPI shift engine and its transmit and receive FIFOs. It watches three completion sources:

- a receive word finishing in byte mode;
- a transmit byte finishing in byte mode;
- a block transfer finishing.

Each source latches into its own flag. A per-source enable decides whether that flag drives the single interrupt line. The block also keeps one sticky FIFO error bit. Software tells a transmit underflow from a receive overflow by looking at the FIFO empty and full levels at the same time.

The block also holds the receive word length for the shift engine. A length code of zero means a full 8-bit word. Codes one to seven mean that many bits. The block counts sampled bits itself and raises the receive completion after the configured number of bits.

Software reaches the block through a small register bus with three addresses:

- address 0: the interrupt enable register (read/write);
- address 1: the status register (read-only, but writable for clearing flags);
- address 2: the receive length register (read/write).

Address 3 reads as zero. All registers are 16 bits wide and reset to zero.

Top module: `spi_irq_status`

## Requirements
- R1: After reset, the enable, status and length registers read 0x0000, `irq` is 0 and `rx_len_bits` is 8.
- R2: Enable register bits are mapped as follows: bit 2 enables receive, bit 1 enables transmit, bit 0 enables transfer. Writes to bits 15..3 are dropped, and those bits always read 0. In the status register, bits 15..8 and 6..3 read 0.
- R3: Length register bits 2..0 hold a code L. `rx_len_bits` is 8 when L is 0 and L otherwise. `rx_word_done` is high during the `rx_bit_strobe` cycle that completes `rx_len_bits` strobes. After that edge, status bit 2 is set.
- R4: A `tx_byte_done` pulse sets status bit 1. A `xfer_done` pulse sets status bit 0. Each flag sets whether or not its enable bit is set.
- R5: A status read returns the flags held before the read edge, then clears bits 2..0. A status write clears each of bits 2..0 for which the written bit is 1 and leaves the others.
- R6: `irq` is a register. It equals the OR over the three sources of flag AND enable, one cycle after the flag changes.
- R7: Status bit 7 sets on `tx_pop` while `tx_empty` is high, or on `rx_push` while `rx_full` is high. The same strobes with the level low leave it clear.
- R8: Status bit 7 survives status reads and status writes. It clears only on a `fifo_init` cycle, and `fifo_init` wins over a coinciding error event.
- R9: If a flag event and a clear of that flag land in the same cycle, the flag ends up set.
- R10: A write to the length register restarts the receive bit count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address (0 enable, 1 status, 2 length) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears flags) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| rx_bit_strobe | input | 1 | One received bit sampled by the shifter |
| tx_byte_done | input | 1 | Byte-mode transmit completed |
| xfer_done | input | 1 | Block-mode transfer completed |
| tx_pop | input | 1 | Shifter read strobe on the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty level |
| rx_push | input | 1 | Write strobe into the receive FIFO |
| rx_full | input | 1 | Receive FIFO full level |
| fifo_init | input | 1 | FIFO initialise command |
| rx_word_done | output | 1 | Receive word complete pulse |
| rx_len_bits | output | 4 | Active receive length, 1 to 8 |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume three things about the inputs:

- every source input is a single-cycle strobe sampled on the rising edge;
- `rst_n` holds the block in reset long enough for each register to load its reset value;
- `bus_rd` and `bus_wr` are never high together.

The stimulus keeps to these rules in two ways. All inputs change only on the falling edge, and every bus access is one cycle long with exactly one strobe raised. Coincident events are applied only where R8 and R9 call for them.

// File: rtl/spi_irq_status.sv
module spi_irq_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rx_bit_strobe,
  input  logic        tx_byte_done,
  input  logic        xfer_done,
  input  logic        tx_pop,
  input  logic        tx_empty,
  input  logic        rx_push,
  input  logic        rx_full,
  input  logic        fifo_init,
  output logic        rx_word_done,
  output logic [3:0]  rx_len_bits,
  output logic        irq
);
  localparam logic [1:0] ADDR_EN  = 2'd0;
  localparam logic [1:0] ADDR_ST  = 2'd1;
  localparam logic [1:0] ADDR_LEN = 2'd2;

  logic [2:0] en_q, flag_q, len_q, cnt_q;
  logic       err_q;
  logic [2:0] set_v, clr_v;
  logic       sel_st, err_evt;

  assign sel_st      = (bus_addr == ADDR_ST);
  assign rx_len_bits = (len_q == 3'd0) ? 4'd8 : {1'b0, len_q};
  assign rx_word_done = rx_bit_strobe && (({1'b0, cnt_q} + 4'd1) == rx_len_bits);
  assign set_v   = {rx_word_done, tx_byte_done, xfer_done};
  assign clr_v   = (bus_rd && sel_st) ? 3'b111 :
                   (bus_wr && sel_st) ? bus_wdata[2:0] : 3'b000;
  assign err_evt = (tx_pop && tx_empty) || (rx_push && rx_full);

  always_comb begin
    bus_rdata = 16'h0000;
    case (bus_addr)
      ADDR_EN:  bus_rdata[2:0] = en_q;
      ADDR_ST:  bus_rdata = {8'h00, err_q, 4'h0, flag_q};
      ADDR_LEN: bus_rdata[2:0] = len_q;
      default:  bus_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      flag_q <= '0;
      err_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADDR_EN)  en_q  <= bus_wdata[2:0];
      if (bus_wr && bus_addr == ADDR_LEN) begin
        len_q <= bus_wdata[2:0];
        cnt_q <= '0;
      end else if (rx_bit_strobe) begin
        cnt_q <= rx_word_done ? 3'd0 : cnt_q + 3'd1;
      end
      flag_q <= (flag_q & ~clr_v) | set_v;
      if (fifo_init)    err_q <= 1'b0;
      else if (err_evt) err_q <= 1'b1;
      irq <= |(flag_q & en_q);
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[15:8] == 8'h00 && bus_rdata[6:3] == 4'h0); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < rx_len_bits); // R3
  AST_RX_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2]) |-> $past(rx_bit_strobe)); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(flag_q != 3'b000)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !fifo_init) |=> err_q); // R8
  AST_ERR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_init |=> !err_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_done |=> flag_q[1]); // R9
endmodule

// File: tb/spi_irq_status_tb.sv
module spi_irq_status_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic rx_bit_strobe = 0, tx_byte_done = 0, xfer_done = 0;
  logic tx_pop = 0, tx_empty = 0, rx_push = 0, rx_full = 0, fifo_init = 0;
  logic rx_word_done, irq;
  logic [3:0] rx_len_bits;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_bit_strobe(rx_bit_strobe),
    .tx_byte_done(tx_byte_done), .xfer_done(xfer_done), .tx_pop(tx_pop),
    .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full), .fifo_init(fifo_init),
    .rx_word_done(rx_word_done), .rx_len_bits(rx_len_bits), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      rx_bit_strobe = 1;
      @(negedge clk);
      rx_bit_strobe = 0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R1 enable", d, 16'h0);
    rd(2'd1, d); check("R1 status", d, 16'h0);
    rd(2'd2, d); check("R1 length", d, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 rx_len_bits", {12'h0, rx_len_bits}, 16'd8);
  endtask

  task automatic t_enable_reg();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF); rd(2'd0, d); check("R2 reserved dropped", d, 16'h0007);
    wr(2'd0, 16'h0005); rd(2'd0, d); check("R2 enable rw", d, 16'h0005);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_sources();
    logic [15:0] d;
    tx_byte_done = 1; @(negedge clk); tx_byte_done = 0;
    rd(2'd1, d); check("R4 tx flag with enable off", d, 16'h0002);
    check("R6 irq gated", {15'h0, irq}, 16'h0);
    rd(2'd1, d); check("R5 read clears", d, 16'h0000);
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    rd(2'd1, d); check("R4 xfer flag", d, 16'h0001);
  endtask

  task automatic t_rx_len();
    logic [15:0] d;
    strobes(7);
    rd(2'd1, d); check("R3 no flag after 7 of 8", d, 16'h0);
    rx_bit_strobe = 1;
    #1 check("R3 word done on 8th", {15'h0, rx_word_done}, 16'h1);
    @(negedge clk); rx_bit_strobe = 0;
    rd(2'd1, d); check("R3 flag after 8", d, 16'h0004);
    wr(2'd2, 16'hFFF3);
    rd(2'd2, d); check("R3 length readback", d, 16'h0003);
    check("R3 rx_len_bits 3", {12'h0, rx_len_bits}, 16'd3);
    strobes(3);
    rd(2'd1, d); check("R3 flag after 3", d, 16'h0004);
    strobes(2);
    wr(2'd2, 16'h0003);
    strobes(2);
    rd(2'd1, d); check("R10 count restarted", d, 16'h0);
    strobes(1);
    rd(2'd1, d); check("R10 flag after restart", d, 16'h0004);
    wr(2'd2, 16'h0001);
    rx_bit_strobe = 1;
    #1 check("R3 length 1 done", {15'h0, rx_word_done}, 16'h1);
    @(negedge clk); rx_bit_strobe = 0;
    wr(2'd2, 16'h0000);
    rd(2'd1, d);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    tx_byte_done = 1; xfer_done = 1; @(negedge clk); tx_byte_done = 0; xfer_done = 0;
    wr(2'd1, 16'h0001);
    rd(2'd1, d); check("R5 w1c clears only bit 0", d, 16'h0002);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(2'd0, 16'h0002);
    tx_byte_done = 1; @(negedge clk); tx_byte_done = 0;
    check("R6 irq lags flag", {15'h0, irq}, 16'h0);
    idle(1);
    check("R6 irq asserted", {15'h0, irq}, 16'h1);
    rd(2'd1, d);
    check("R6 irq held one cycle after clear", {15'h0, irq}, 16'h1);
    idle(1);
    check("R6 irq drops", {15'h0, irq}, 16'h0);
    wr(2'd0, 16'h0001);
    tx_byte_done = 1; @(negedge clk); tx_byte_done = 0;
    idle(3);
    check("R6 disabled source no irq", {15'h0, irq}, 16'h0);
    rd(2'd1, d);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_err();
    logic [15:0] d;
    tx_pop = 1; @(negedge clk); tx_pop = 0;
    rx_push = 1; @(negedge clk); rx_push = 0;
    rd(2'd1, d); check("R7 no error when levels low", d, 16'h0);
    tx_empty = 1; tx_pop = 1; @(negedge clk); tx_pop = 0;
    rd(2'd1, d); check("R7 underflow sets bit 7", d, 16'h0080);
    check("R7 tx_empty seen", {15'h0, tx_empty}, 16'h1);
    tx_empty = 0;
    rd(2'd1, d); check("R8 sticky over read", d, 16'h0080);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); check("R8 sticky over write", d, 16'h0080);
    fifo_init = 1; @(negedge clk); fifo_init = 0;
    rd(2'd1, d); check("R8 init clears", d, 16'h0);
    rx_full = 1; rx_push = 1; @(negedge clk); rx_push = 0;
    rd(2'd1, d); check("R7 overflow sets bit 7", d, 16'h0080);
    rx_push = 1; fifo_init = 1; @(negedge clk); rx_push = 0; fifo_init = 0;
    rx_full = 0;
    rd(2'd1, d); check("R8 init beats event", d, 16'h0);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    tx_byte_done = 1; bus_addr = 2'd1; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); tx_byte_done = 0; bus_rd = 0;
    check("R9 read shows pre-set value", d, 16'h0);
    rd(2'd1, d); check("R9 set wins over read clear", d, 16'h0002);
    xfer_done = 1;
    wr(2'd1, 16'h0001);
    xfer_done = 0;
    rd(2'd1, d); check("R9 set wins over w1c", d, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable_reg();
    t_sources();
    t_rx_len();
    t_w1c();
    t_irq();
    t_err();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule